// File: doc/BRIEF.md
# Speculative Epoch Lifecycle Controller

This block follows one speculative epoch on a single processor context from the moment it is spawned until it either commits or is thrown away and run again. After a spawn the epoch spends one cycle in initialisation and then does its speculative work. When the work is finished it waits for the ordered commit token. The token arrives only once every earlier epoch has committed. While it holds the token it asks the memory side to commit and waits for the acknowledge. It then hands the token on to the next epoch. If a dependence violation is reported before the epoch becomes homefree, the speculative work is discarded and the epoch starts again from initialisation. Cache line state, coherence traffic and the commit buffer are outside the block. It reaches them only through the commit request and acknowledge pair and through the squash pulse.

Every spawn gives the epoch a sequence number. The numbers grow in program order across all contexts, and the coherence logic uses them for its comparisons. A small set of forwarding channels carries compiler-inserted wait and signal pairs. A consumer load that waits on a channel is stalled until the producer epoch signals that channel, so a predictable dependence does not turn into a violation.

Top module: `epoch_lifecycle_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, start_work_o, squash_o, commit_req_o, token_out_o, stall_o are low, and epoch_num_o and sig_out_o are zero.
- R2: spawn_i is accepted only when the epoch is idle. It raises start_work_o for the next cycle, which is the initialisation cycle. Without a violation the epoch then moves to speculative work. A spawn in any other phase has no effect.
- R3: The first accepted spawn after reset sets epoch_num_o to CTX_ID. Each later accepted spawn adds NUM_CTX, modulo 2^EPOCH_W. The value changes on no other event.
- R4: violation_i during initialisation, speculative work or waiting for the token gives a one-cycle squash_o pulse on the next cycle. In that same cycle the epoch is back in initialisation with start_work_o high, which is the retry.
- R5: When violation_i and work_done_i arrive in the same speculative-work cycle, the squash wins and the epoch does not complete.
- R6: work_done_i without the token moves the epoch into a waiting phase with commit_req_o low. The epoch stays there until token_in_i, then raises commit_req_o on the next cycle.
- R7: Fast commit: when the token is already held, or token_in_i arrives in the same cycle as work_done_i, commit_req_o rises on the next cycle with no waiting phase.
- R8: commit_req_o stays high until commit_done_i. violation_i is ignored while committing.
- R9: commit_done_i while committing gives a single-cycle token_out_o pulse on the next cycle. The epoch returns to idle and no longer holds the token.
- R10: stall_o is high when any wait_i bit names a channel whose signal has not arrived, either earlier since the spawn or on sig_in_i in the current cycle. It is forced low while the token is held or arriving.
- R11: sig_out_o bit k is set by sig_set_i bit k during speculative work and ignored in other phases. It holds until an accepted spawn or squash clears it, and the clear wins over a set in the same cycle. Arrived input signals are cleared only by an accepted spawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_i | input | 1 | Start a new epoch on this context |
| work_done_i | input | 1 | Speculative work has finished |
| violation_i | input | 1 | Dependence violation detected |
| token_in_i | input | 1 | Commit token from the previous epoch |
| commit_done_i | input | 1 | Acknowledge of commit_req_o |
| wait_i | input | NCH | Consumer loads waiting on each channel |
| sig_in_i | input | NCH | Signals arriving from the producer epoch |
| sig_set_i | input | NCH | This epoch's producer stores done, per channel |
| start_work_o | output | 1 | Initialisation cycle; work starts or restarts |
| squash_o | output | 1 | Discard speculative state (one-cycle pulse) |
| commit_req_o | output | 1 | Request to commit speculative state |
| token_out_o | output | 1 | Commit token to the next epoch (pulse) |
| epoch_num_o | output | EPOCH_W | Program-order number of this epoch |
| stall_o | output | 1 | Hold the waiting consumer load |
| sig_out_o | output | NCH | Signals sent to the next epoch |

## Verification
Two pairs of events can land on the same edge. A violation can meet work-done during speculative work, and a violation can arrive while the epoch is committing. The token can also arrive on the very cycle work finishes. Directed sequences place each of these coincidences on one edge, and biased random traffic then produces them many more times. A bench model that applies the stated priorities judges every cycle. The losing event must leave no trace on squash_o, commit_req_o, token_out_o or sig_out_o.

// File: rtl/epoch_pkg.sv
package epoch_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_INIT   = 3'd1,
    PH_SPEC   = 3'd2,
    PH_WAITHF = 3'd3,
    PH_COMMIT = 3'd4
  } phase_t;

  function automatic logic is_speculative(input phase_t p);
    return (p == PH_INIT) || (p == PH_SPEC) || (p == PH_WAITHF);
  endfunction
endpackage

// File: rtl/epoch_fsm.sv
module epoch_fsm
  import epoch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   spawn_i,
  input  logic   work_done_i,
  input  logic   violation_i,
  input  logic   token_in_i,
  input  logic   commit_done_i,
  output phase_t phase_o,
  output logic   homefree_o,
  output logic   ev_spawn_o,
  output logic   ev_squash_o,
  output logic   squash_o,
  output logic   token_out_o
);
  phase_t phase_q, phase_d;
  logic   tok_q, sq_q, tout_q;
  logic   ev_pass;

  assign homefree_o  = tok_q | token_in_i;
  assign ev_spawn_o  = (phase_q == PH_IDLE) && spawn_i;
  assign ev_squash_o = is_speculative(phase_q) && violation_i;
  assign ev_pass     = (phase_q == PH_COMMIT) && commit_done_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (spawn_i) phase_d = PH_INIT;
      PH_INIT:   phase_d = violation_i ? PH_INIT : PH_SPEC;
      PH_SPEC: begin
        if (violation_i)      phase_d = PH_INIT;
        else if (work_done_i) phase_d = homefree_o ? PH_COMMIT : PH_WAITHF;
      end
      PH_WAITHF: begin
        if (violation_i)     phase_d = PH_INIT;
        else if (homefree_o) phase_d = PH_COMMIT;
      end
      PH_COMMIT: if (commit_done_i) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tok_q   <= 1'b0;
      sq_q    <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tok_q   <= homefree_o & ~ev_pass;
      sq_q    <= ev_squash_o;
      tout_q  <= ev_pass;
    end
  end

  assign phase_o     = phase_q;
  assign squash_o    = sq_q;
  assign token_out_o = tout_q;

  a_r4_squash_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_squash_o |=> (squash_o && phase_q == PH_INIT));
  a_r5_squash_beats_done: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SPEC && violation_i && work_done_i) |=> phase_q == PH_INIT);
  a_r8_commit_ignores_violation: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COMMIT && !commit_done_i) |=> phase_q == PH_COMMIT);
  a_r9_token_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    token_out_o |=> !token_out_o);
  a_r6_commit_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_COMMIT && phase_d == PH_COMMIT) |-> homefree_o);
endmodule

// File: rtl/epoch_counter.sv
module epoch_counter #(
  parameter int EPOCH_W = 16,
  parameter int NUM_CTX = 4,
  parameter int CTX_ID  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  output logic [EPOCH_W-1:0] epoch_o
);
  localparam logic [EPOCH_W-1:0] STEP  = EPOCH_W'(NUM_CTX);
  localparam logic [EPOCH_W-1:0] FIRST = EPOCH_W'(CTX_ID);

  function automatic logic [EPOCH_W-1:0] next_epoch(
    input logic [EPOCH_W-1:0] cur, input logic started);
    return started ? cur + STEP : FIRST;
  endfunction

  logic [EPOCH_W-1:0] num_q;
  logic               started_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q     <= '0;
      started_q <= 1'b0;
    end else if (load_i) begin
      num_q     <= next_epoch(num_q, started_q);
      started_q <= 1'b1;
    end
  end

  assign epoch_o = num_q;

  a_r3_moves_only_on_spawn: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(epoch_o));
  a_r3_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && started_q) |=> (epoch_o - $past(epoch_o)) == STEP);
endmodule

// File: rtl/fwd_flags.sv
module fwd_flags #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_in_i,
  input  logic           clr_out_i,
  input  logic           in_spec_i,
  input  logic           homefree_i,
  input  logic [NCH-1:0] wait_i,
  input  logic [NCH-1:0] sig_in_i,
  input  logic [NCH-1:0] sig_set_i,
  output logic           stall_o,
  output logic [NCH-1:0] sig_out_o
);
  logic [NCH-1:0] arrived_q, sent_q, blocked;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arrived_q[k] <= 1'b0;
        sent_q[k]    <= 1'b0;
      end else begin
        arrived_q[k] <= (arrived_q[k] & ~clr_in_i) | sig_in_i[k];
        sent_q[k]    <= clr_out_i ? 1'b0 : (sent_q[k] | (in_spec_i & sig_set_i[k]));
      end
    end
    assign blocked[k] = wait_i[k] & ~(arrived_q[k] | sig_in_i[k]);
  end

  assign stall_o   = (|blocked) & ~homefree_i;
  assign sig_out_o = sent_q;

  a_r10_no_stall_homefree: assert property (@(posedge clk) disable iff (!rst_n)
    homefree_i |-> !stall_o);
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_out_i |=> sig_out_o == '0);
  a_r11_sent_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_out_i |=> ((sig_out_o & $past(sig_out_o)) == $past(sig_out_o)));
endmodule

// File: rtl/epoch_lifecycle_ctrl.sv
module epoch_lifecycle_ctrl
  import epoch_pkg::*;
#(
  parameter int EPOCH_W = 16,
  parameter int NUM_CTX = 4,
  parameter int CTX_ID  = 1,
  parameter int NCH     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spawn_i,
  input  logic               work_done_i,
  input  logic               violation_i,
  input  logic               token_in_i,
  input  logic               commit_done_i,
  input  logic [NCH-1:0]     wait_i,
  input  logic [NCH-1:0]     sig_in_i,
  input  logic [NCH-1:0]     sig_set_i,
  output logic               start_work_o,
  output logic               squash_o,
  output logic               commit_req_o,
  output logic               token_out_o,
  output logic [EPOCH_W-1:0] epoch_num_o,
  output logic               stall_o,
  output logic [NCH-1:0]     sig_out_o
);
  phase_t phase;
  logic   homefree, ev_spawn, ev_squash;

  epoch_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .spawn_i(spawn_i), .work_done_i(work_done_i),
    .violation_i(violation_i), .token_in_i(token_in_i), .commit_done_i(commit_done_i),
    .phase_o(phase), .homefree_o(homefree), .ev_spawn_o(ev_spawn),
    .ev_squash_o(ev_squash), .squash_o(squash_o), .token_out_o(token_out_o)
  );

  epoch_counter #(.EPOCH_W(EPOCH_W), .NUM_CTX(NUM_CTX), .CTX_ID(CTX_ID)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(ev_spawn), .epoch_o(epoch_num_o)
  );

  fwd_flags #(.NCH(NCH)) u_fwd (
    .clk(clk), .rst_n(rst_n), .clr_in_i(ev_spawn), .clr_out_i(ev_spawn | ev_squash),
    .in_spec_i(phase == PH_SPEC), .homefree_i(homefree), .wait_i(wait_i),
    .sig_in_i(sig_in_i), .sig_set_i(sig_set_i), .stall_o(stall_o), .sig_out_o(sig_out_o)
  );

  assign start_work_o = (phase == PH_INIT);
  assign commit_req_o = (phase == PH_COMMIT);

  a_r2_spawn_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_spawn |=> start_work_o);
  a_r3_epoch_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(epoch_num_o) |-> (start_work_o && !squash_o));
  a_r8_commit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req_o && !commit_done_i) |=> commit_req_o);
  a_r9_pass_ends_commit: assert property (@(posedge clk) disable iff (!rst_n)
    token_out_o |-> !commit_req_o && !start_work_o);
endmodule

// File: tb/sim_epoch_lifecycle_ctrl.sv
`timescale 1ns/1ps
module sim_epoch_lifecycle_ctrl;
  localparam int EW = 16, NC = 4, CID = 1, NCH = 4;
  localparam int S_IDLE = 0, S_INIT = 1, S_SPEC = 2, S_WAIT = 3, S_COMMIT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spawn = 0, wdone = 0, viol = 0, tin = 0, cdone = 0;
  logic [NCH-1:0] wt = '0, sin = '0, sset = '0;
  logic start_w, sq, creq, tout, stall;
  logic [EW-1:0]  epoch;
  logic [NCH-1:0] sout;

  int checks = 0, fails = 0;
  int m_state = S_IDLE;
  logic m_tok = 0, m_sq = 0, m_to = 0, m_started = 0;
  logic [EW-1:0]  m_epoch = '0;
  logic [NCH-1:0] m_arr = '0, m_out = '0;

  always #4 clk = ~clk;

  epoch_lifecycle_ctrl #(.EPOCH_W(EW), .NUM_CTX(NC), .CTX_ID(CID), .NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .spawn_i(spawn), .work_done_i(wdone), .violation_i(viol),
    .token_in_i(tin), .commit_done_i(cdone), .wait_i(wt), .sig_in_i(sin), .sig_set_i(sset),
    .start_work_o(start_w), .squash_o(sq), .commit_req_o(creq), .token_out_o(tout),
    .epoch_num_o(epoch), .stall_o(stall), .sig_out_o(sout)
  );

  function automatic logic exp_stall(input logic [NCH-1:0] w, a, s, input logic hf);
    return hf ? 1'b0 : ((w & ~a & ~s) != '0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 start_work", 32'(start_w), 32'(m_state == S_INIT));
    chk("R4 R5 squash", 32'(sq), 32'(m_sq));
    chk("R6 R7 R8 commit_req", 32'(creq), 32'(m_state == S_COMMIT));
    chk("R9 token_out", 32'(tout), 32'(m_to));
    chk("R3 epoch", 32'(epoch), 32'(m_epoch));
    chk("R10 stall", 32'(stall), 32'(exp_stall(wt, m_arr, sin, m_tok | tin)));
    chk("R11 sig_out", 32'(sout), 32'(m_out));
  endtask

  task automatic model_update();
    logic hf, spec, acc_sp, acc_sq, pass;
    int nx;
    hf = m_tok | tin;
    spec = (m_state == S_INIT) || (m_state == S_SPEC) || (m_state == S_WAIT);
    acc_sp = (m_state == S_IDLE) && spawn;
    acc_sq = spec && viol;
    pass = (m_state == S_COMMIT) && cdone;
    nx = m_state;
    if (acc_sp) nx = S_INIT;
    else if (acc_sq) nx = S_INIT;
    else if (m_state == S_INIT) nx = S_SPEC;
    else if (m_state == S_SPEC && wdone) nx = hf ? S_COMMIT : S_WAIT;
    else if (m_state == S_WAIT && hf) nx = S_COMMIT;
    else if (pass) nx = S_IDLE;
    if (acc_sp || acc_sq) m_out = '0;
    else if (m_state == S_SPEC) m_out = m_out | sset;
    m_arr = (acc_sp ? '0 : m_arr) | sin;
    if (acc_sp) begin
      m_epoch = m_started ? m_epoch + EW'(NC) : EW'(CID);
      m_started = 1'b1;
    end
    m_tok = hf & ~pass;
    m_sq = acc_sq;
    m_to = pass;
    m_state = nx;
  endtask

  task automatic step(input logic sp, wd, vi, ti, cd, input logic [NCH-1:0] w, si, ss);
    @(negedge clk);
    spawn = sp; wdone = wd; viol = vi; tin = ti; cdone = cd; wt = w; sin = si; sset = ss;
    #1 check_all();
    @(posedge clk);
    model_update();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset start_work", 32'(start_w), 0);
    chk("R1 reset outputs", 32'({sq, creq, tout, stall}), 0);
    chk("R1 reset epoch", 32'(epoch), 0);
    chk("R1 reset sig_out", 32'(sout), 0);
    rst_n = 1'b1;
    // R2 R3: spawn, then a spawn during work is ignored; R11 signal set during work
    step(1,0,0,0,0, '0, '0, '0);
    step(1,0,0,0,0, 4'b0001, '0, '0);
    step(1,0,0,0,0, 4'b0001, 4'b0001, 4'b0010);
    // R5: violation and work_done on the same edge, squash wins
    step(0,1,1,0,0, '0, '0, '0);
    step(0,0,0,0,0, 4'b0011, '0, '0);
    // R6: done without token, wait, then token arrives
    step(0,1,0,0,0, '0, '0, 4'b0100);
    step(0,0,0,0,0, '0, '0, '0);
    step(0,0,0,1,0, 4'b0010, '0, '0);
    // R8: violation while committing is ignored
    step(0,0,1,0,0, '0, '0, '0);
    step(0,0,1,0,1, '0, '0, '0);
    // R9: token passed
    step(0,0,0,0,0, '0, '0, '0);
    // R7: fast commit with token arriving the same cycle as work_done; R3 second number
    step(1,0,0,0,0, '0, '0, '0);
    step(0,0,0,0,0, '0, '0, '0);
    step(0,1,0,1,0, '0, '0, '0);
    step(0,0,0,0,1, '0, '0, '0);
    step(0,0,0,0,0, '0, '0, '0);
    // R4: violation in init and in the waiting phase
    step(1,0,0,0,0, '0, '0, '0);
    step(0,0,1,0,0, '0, '0, '0);
    step(0,0,0,0,0, '0, '0, '0);
    step(0,1,0,0,0, '0, '0, '0);
    step(0,0,1,0,0, '0, '0, '0);
    step(0,0,0,0,0, '0, '0, '0);
    // random traffic, all requirements
    for (int i = 0; i < 6000; i++) begin
      logic sp, wd, vi, ti, cd;
      sp = ($urandom % 4) == 0;
      wd = ($urandom % 4) == 0;
      vi = ($urandom % 9) == 0;
      ti = !m_tok && (($urandom % 6) == 0);
      cd = ($urandom % 3) == 0;
      step(sp, wd, vi, ti, cd, NCH'($urandom), NCH'($urandom % 3 == 0 ? $urandom : 0),
           NCH'($urandom));
    end
    summary();
  end
endmodule